// File: doc/BRIEF.md
# LIN Transceiver Mode and Wake Controller

This block is the control state machine of a single-wire automotive bus transceiver. It moves the device between four modes: unpowered, pre-normal, normal and sleep. The inputs are a supply-good flag from an undervoltage comparator, the enable pin, the received bus level and a local wake pin. The outputs drive the regulator inhibit switch, the transmit/receive path enable, the bus termination enable, the level placed on the receive pin, and the strength of the pull-down on the transmit pin.

In sleep the block watches the bus and the wake pin through two separate debounce filters. Each filter has its own length in clock ticks. When a wake is accepted, the block enters pre-normal mode, turns the regulator and the termination back on, and pulls the receive pin low as a wake request. The strength of the transmit-pin pull-down tells the host which source caused the wake. Raising enable clears both indications, and enable held high for its qualification time starts normal operation.

All times are parameters counted in clock ticks. The two wake filter lengths must be at least 2 ticks. Analog thresholds and pin drivers sit outside this block.

Top module: `lin_phy_mode_ctrl`

## Requirements
- R1: During and after a synchronous reset with the supply flag low, the block is unpowered: inhibit, communication, termination and strong pull-down are 0, and the receive output is 1 (1 means recessive or released).
- R2: From unpowered, the block enters pre-normal once the supply flag has been sampled high on PWRUP_TICKS consecutive clocks. Pre-normal gives inhibit 1, termination 1, communication 0 and receive output 1 when no wake flag is set. Any low sample restarts the count.
- R3: A low sample of the supply flag sends the block to unpowered on the next clock from any mode, clearing both wake flags.
- R4: From pre-normal, enable sampled high on NORM_TICKS consecutive clocks enters normal mode, with inhibit, communication and termination all 1. In normal mode the receive output copies the bus level one clock later. A shorter high pulse has no effect.
- R5: From normal, enable sampled low on SLEEP_TICKS consecutive clocks enters sleep, with inhibit, communication and termination 0 and the receive output 1. A shorter low pulse leaves normal mode running.
- R6: In sleep, a falling bus edge followed by BUS_FILT_TICKS consecutive dominant samples (bus level 0), counting the first low sample, is a remote wake. It causes pre-normal with receive output 0 and strong pull-down 0.
- R7: In sleep, a falling edge on the active-low wake pin followed by WAKE_FILT_TICKS consecutive low samples is a local wake. It causes pre-normal with receive output 0 and strong pull-down 1.
- R8: If a monitored line returns high before its filter length is reached, no wake occurs, and the next falling edge restarts the count from one.
- R9: In pre-normal, enable sampled high clears the wake flag and the source flag on the next clock: the receive output goes to 1 and the strong pull-down goes to 0.
- R10: Wake detection is armed only in sleep. Wake pin activity in normal or pre-normal has no effect. A line that is already low when sleep begins does not wake the block until it produces a new falling edge.
- R11: If the local and remote filters both complete on the same clock, the local source is reported (strong pull-down 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts in its ticks |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Battery supply above the undervoltage threshold |
| en_in | input | 1 | Enable pin level from the host |
| bus_rx | input | 1 | Received bus level, 1 recessive, 0 dominant |
| wake_n | input | 1 | Local wake pin, active low |
| inh_on | output | 1 | Regulator inhibit switch closed |
| comm_en | output | 1 | Transmit and receive path enabled |
| term_en | output | 1 | Bus termination resistor connected |
| rxd_out | output | 1 | Receive pin level: bus data in normal, inverted wake flag in pre-normal, 1 otherwise |
| txd_strong_pd | output | 1 | Strong pull-down on the transmit pin, signalling a local wake |

## Verification
The assertions assume that supply_ok, en_in, bus_rx and wake_n are synchronous to clk and stable around its rising edge. The bench meets this by changing every input only on the falling edge. The properties also assume that the host can raise enable at any moment in pre-normal and that the next clock may enter normal mode, so the flag-clear check accepts either outcome. The stimulus sweeps every hold and filter length from one tick up to one past its threshold using a small parameter set, so each limit is crossed in both directions and also restarted.

// File: rtl/lin_ctrl_pkg.sv
`timescale 1ns/1ps
package lin_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_PRE    = 2'd1,
    MODE_NORMAL = 2'd2,
    MODE_SLEEP  = 2'd3
  } lin_mode_e;

  typedef struct packed {
    lin_mode_e mode;
    logic      wake_flag;
    logic      src_local;
  } lin_ctrl_state_t;

  localparam int unsigned N_WAKE_SRC = 2;
  localparam int unsigned SRC_REMOTE = 0;
  localparam int unsigned SRC_LOCAL  = 1;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/lin_hold_timer.sv
`timescale 1ns/1ps
module lin_hold_timer
  import lin_ctrl_pkg::*;
#(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_cond,
  output logic hold_done
);

  localparam int unsigned CW = cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !hold_cond) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hold_done = hold_cond && (cnt_q == LAST);

endmodule

// File: rtl/lin_wake_filter.sv
`timescale 1ns/1ps
module lin_wake_filter
  import lin_ctrl_pkg::*;
#(
  parameter int unsigned FILT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic line_n,
  output logic fire
);

  localparam int unsigned CW = cnt_width(FILT);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          prev_q;
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          fall_seen;

  assign fall_seen = prev_q && !line_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= line_n;
      if (!armed || line_n) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (fall_seen) begin
        run_q <= 1'b1;
        cnt_q <= ONE;
      end else if (run_q && (cnt_q != LAST)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fire = armed && run_q && !line_n && (cnt_q == LAST);

endmodule

// File: rtl/lin_pin_stage.sv
`timescale 1ns/1ps
module lin_pin_stage
  import lin_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  lin_ctrl_state_t nxt,
  input  logic            bus_rx,
  output logic            inh_on,
  output logic            comm_en,
  output logic            term_en,
  output logic            rxd_out,
  output logic            txd_strong_pd
);

  logic powered_nxt;
  logic rxd_nxt;

  assign powered_nxt = (nxt.mode == MODE_PRE) || (nxt.mode == MODE_NORMAL);

  always_comb begin
    unique case (nxt.mode)
      MODE_NORMAL: rxd_nxt = bus_rx;
      MODE_PRE:    rxd_nxt = !nxt.wake_flag;
      default:     rxd_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_on        <= 1'b0;
      comm_en       <= 1'b0;
      term_en       <= 1'b0;
      rxd_out       <= 1'b1;
      txd_strong_pd <= 1'b0;
    end else begin
      inh_on        <= powered_nxt;
      comm_en       <= (nxt.mode == MODE_NORMAL);
      term_en       <= powered_nxt;
      rxd_out       <= rxd_nxt;
      txd_strong_pd <= (nxt.mode == MODE_PRE) && nxt.wake_flag && nxt.src_local;
    end
  end

endmodule

// File: rtl/lin_phy_mode_ctrl.sv
`timescale 1ns/1ps
module lin_phy_mode_ctrl
  import lin_ctrl_pkg::*;
#(
  parameter int unsigned PWRUP_TICKS     = 200,
  parameter int unsigned NORM_TICKS      = 10,
  parameter int unsigned SLEEP_TICKS     = 10,
  parameter int unsigned BUS_FILT_TICKS  = 90,
  parameter int unsigned WAKE_FILT_TICKS = 130
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic en_in,
  input  logic bus_rx,
  input  logic wake_n,
  output logic inh_on,
  output logic comm_en,
  output logic term_en,
  output logic rxd_out,
  output logic txd_strong_pd
);

  lin_ctrl_state_t st_q, st_d;

  logic pwr_done, norm_done, sleep_done;
  logic armed;
  logic [N_WAKE_SRC-1:0] src_line;
  logic [N_WAKE_SRC-1:0] src_fire;

  lin_hold_timer #(.HOLD(PWRUP_TICKS)) pwr_tmr_i (
    .clk(clk), .rst(rst),
    .hold_cond(supply_ok && (st_q.mode == MODE_OFF)),
    .hold_done(pwr_done)
  );

  lin_hold_timer #(.HOLD(NORM_TICKS)) norm_tmr_i (
    .clk(clk), .rst(rst),
    .hold_cond(supply_ok && en_in && (st_q.mode == MODE_PRE)),
    .hold_done(norm_done)
  );

  lin_hold_timer #(.HOLD(SLEEP_TICKS)) sleep_tmr_i (
    .clk(clk), .rst(rst),
    .hold_cond(supply_ok && !en_in && (st_q.mode == MODE_NORMAL)),
    .hold_done(sleep_done)
  );

  assign armed = supply_ok && (st_q.mode == MODE_SLEEP);
  assign src_line[SRC_REMOTE] = bus_rx;
  assign src_line[SRC_LOCAL]  = wake_n;

  for (genvar g = 0; g < N_WAKE_SRC; g++) begin : g_wake
    localparam int unsigned FLEN = (g == SRC_LOCAL) ? WAKE_FILT_TICKS : BUS_FILT_TICKS;
    lin_wake_filter #(.FILT(FLEN)) filt_i (
      .clk(clk), .rst(rst),
      .armed(armed),
      .line_n(src_line[g]),
      .fire(src_fire[g])
    );
  end

  always_comb begin
    st_d = st_q;
    if (!supply_ok) begin
      st_d.mode      = MODE_OFF;
      st_d.wake_flag = 1'b0;
      st_d.src_local = 1'b0;
    end else begin
      unique case (st_q.mode)
        MODE_OFF: begin
          if (pwr_done) begin
            st_d.mode      = MODE_PRE;
            st_d.wake_flag = 1'b0;
            st_d.src_local = 1'b0;
          end
        end
        MODE_PRE: begin
          if (en_in) begin
            st_d.wake_flag = 1'b0;
            st_d.src_local = 1'b0;
          end
          if (norm_done) st_d.mode = MODE_NORMAL;
        end
        MODE_NORMAL: begin
          if (sleep_done) st_d.mode = MODE_SLEEP;
        end
        MODE_SLEEP: begin
          if (|src_fire) begin
            st_d.mode      = MODE_PRE;
            st_d.wake_flag = 1'b1;
            st_d.src_local = src_fire[SRC_LOCAL];
          end
        end
        default: st_d.mode = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q.mode      <= MODE_OFF;
      st_q.wake_flag <= 1'b0;
      st_q.src_local <= 1'b0;
    end else begin
      st_q <= st_d;
    end
  end

  lin_pin_stage pins_i (
    .clk(clk), .rst(rst),
    .nxt(st_d),
    .bus_rx(bus_rx),
    .inh_on(inh_on),
    .comm_en(comm_en),
    .term_en(term_en),
    .rxd_out(rxd_out),
    .txd_strong_pd(txd_strong_pd)
  );

endmodule

// File: rtl/lin_phy_mode_ctrl_chk.sv
`timescale 1ns/1ps
module lin_phy_mode_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic en_in,
  input logic inh_on,
  input logic comm_en,
  input logic term_en,
  input logic rxd_out,
  input logic txd_strong_pd
);

  AST_COMM_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
    comm_en |-> (inh_on && term_en)); // R4

  AST_COMM_RISE_FROM_PRE: assert property (@(posedge clk) disable iff (rst)
    $rose(comm_en) |-> $past(inh_on)); // R4

  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!inh_on && !comm_en && !term_en && !txd_strong_pd)); // R3

  AST_STRONG_ONLY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    txd_strong_pd |-> (!rxd_out && inh_on && !comm_en)); // R7

  AST_ENABLE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (inh_on && !comm_en && en_in) |=> (!txd_strong_pd && (rxd_out || comm_en))); // R9

  AST_INH_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(inh_on) |-> ($past(!supply_ok) || $past(comm_en))); // R5

  AST_UNPOWERED_RXD_HIGH: assert property (@(posedge clk) disable iff (rst)
    !inh_on |-> rxd_out); // R5

endmodule

bind lin_phy_mode_ctrl lin_phy_mode_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .en_in(en_in),
  .inh_on(inh_on), .comm_en(comm_en), .term_en(term_en),
  .rxd_out(rxd_out), .txd_strong_pd(txd_strong_pd)
);

// File: tb/lin_phy_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module lin_phy_mode_ctrl_tb_top;

  localparam int PW = 4;
  localparam int NM = 3;
  localparam int SL = 3;
  localparam int BF = 5;
  localparam int WF = 8;

  // pin bundle {inh, comm, term, rxd, strong}
  localparam logic [4:0] P_OFF = 5'b00010;
  localparam logic [4:0] P_PRE = 5'b10110;
  localparam logic [4:0] P_REM = 5'b10100;
  localparam logic [4:0] P_LOC = 5'b10101;
  localparam logic [4:0] P_NRM = 5'b11110;
  localparam logic [4:0] P_SLP = 5'b00010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, en_in = 1'b0, bus_rx = 1'b1, wake_n = 1'b1;
  logic inh_on, comm_en, term_en, rxd_out, txd_strong_pd;
  logic [4:0] pins;
  int vec = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lin_phy_mode_ctrl #(
    .PWRUP_TICKS(PW), .NORM_TICKS(NM), .SLEEP_TICKS(SL),
    .BUS_FILT_TICKS(BF), .WAKE_FILT_TICKS(WF)
  ) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .en_in(en_in),
    .bus_rx(bus_rx), .wake_n(wake_n),
    .inh_on(inh_on), .comm_en(comm_en), .term_en(term_en),
    .rxd_out(rxd_out), .txd_strong_pd(txd_strong_pd)
  );

  assign pins = {inh_on, comm_en, term_en, rxd_out, txd_strong_pd};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [4:0] exp, input string tag);
    vec++;
    if (pins !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, pins, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; supply_ok = 1'b0; en_in = 1'b0; bus_rx = 1'b1; wake_n = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic go_pre;
    do_reset();
    supply_ok = 1'b1;
    cyc(PW);
  endtask

  task automatic go_norm;
    go_pre();
    en_in = 1'b1;
    cyc(NM);
  endtask

  task automatic go_sleep;
    go_norm();
    en_in = 1'b0;
    cyc(SL);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk(P_OFF, "R1 reset state");
    cyc(3);
    chk(P_OFF, "R1 stays unpowered");

    // R2 power-up hold sweep with restart
    for (int L = 1; L <= PW + 1; L++) begin
      do_reset();
      supply_ok = 1'b1;
      cyc(L);
      chk((L >= PW) ? P_PRE : P_OFF, "R2 power-up hold");
      if (L < PW) begin
        supply_ok = 1'b0; cyc(1);
        chk(P_OFF, "R2 dip");
        supply_ok = 1'b1; cyc(PW - 1);
        chk(P_OFF, "R2 restarted count");
        cyc(1);
        chk(P_PRE, "R2 full hold after restart");
      end
    end

    // R4 enable qualification sweep
    for (int L = 1; L <= NM + 1; L++) begin
      go_pre();
      en_in = 1'b1;
      cyc(L);
      chk((L >= NM) ? P_NRM : P_PRE, "R4 enable hold");
      if (L < NM) begin
        en_in = 1'b0; cyc(1);
        chk(P_PRE, "R4 short enable ignored");
      end
    end

    // R4 receive path follows the bus
    go_norm();
    for (int k = 0; k < 6; k++) begin
      bus_rx = logic'((6'b101001 >> k) & 1);
      cyc(1);
      chk({4'b1110, 1'b0} | {3'b000, bus_rx, 1'b0}, "R4 rxd follows bus");
    end
    bus_rx = 1'b1;

    // R5 sleep qualification sweep
    for (int L = 1; L <= SL + 1; L++) begin
      go_norm();
      en_in = 1'b0;
      cyc(L);
      chk((L >= SL) ? P_SLP : P_NRM, "R5 disable hold");
      if (L < SL) begin
        en_in = 1'b1; cyc(1);
        chk(P_NRM, "R5 short low ignored");
      end
    end

    // R6 and R8 remote wake filter sweep
    for (int L = 1; L <= BF + 1; L++) begin
      go_sleep();
      bus_rx = 1'b0;
      cyc(L);
      chk((L >= BF) ? P_REM : P_SLP, "R6 bus dominant hold");
      if (L < BF) begin
        bus_rx = 1'b1; cyc(1);
        chk(P_SLP, "R8 bus released early");
        bus_rx = 1'b0; cyc(BF - 1);
        chk(P_SLP, "R8 bus count restarted");
        cyc(1);
        chk(P_REM, "R8 bus full hold after restart");
      end
    end

    // R7 and R8 local wake filter sweep
    for (int L = 1; L <= WF + 1; L++) begin
      go_sleep();
      wake_n = 1'b0;
      cyc(L);
      chk((L >= WF) ? P_LOC : P_SLP, "R7 wake pin hold");
      if (L < WF) begin
        wake_n = 1'b1; cyc(1);
        chk(P_SLP, "R8 wake released early");
        wake_n = 1'b0; cyc(WF - 1);
        chk(P_SLP, "R8 wake count restarted");
        cyc(1);
        chk(P_LOC, "R8 wake full hold after restart");
      end
    end

    // R9 enable clears flags, then normal follows
    go_sleep();
    wake_n = 1'b0; cyc(WF);
    chk(P_LOC, "R9 local flag set");
    wake_n = 1'b1; cyc(2);
    chk(P_LOC, "R9 flag held without enable");
    en_in = 1'b1; cyc(1);
    chk(P_PRE, "R9 local flags cleared");
    cyc(NM - 1);
    chk(P_NRM, "R9 normal after clear");

    go_sleep();
    bus_rx = 1'b0; cyc(BF);
    chk(P_REM, "R9 remote flag set");
    bus_rx = 1'b1; en_in = 1'b1; cyc(1);
    chk(P_PRE, "R9 remote flag cleared");
    cyc(NM - 1);
    chk(P_NRM, "R9 normal after remote clear");

    // R3 supply loss from every mode
    go_pre();
    supply_ok = 1'b0; cyc(1);
    chk(P_OFF, "R3 loss in pre-normal");
    go_norm();
    supply_ok = 1'b0; cyc(1);
    chk(P_OFF, "R3 loss in normal");
    go_sleep();
    supply_ok = 1'b0; cyc(1);
    chk(P_OFF, "R3 loss in sleep");
    go_sleep();
    wake_n = 1'b0; cyc(WF);
    wake_n = 1'b1;
    supply_ok = 1'b0; cyc(1);
    chk(P_OFF, "R3 loss with wake flag");
    supply_ok = 1'b1; cyc(PW);
    chk(P_PRE, "R3 flags gone after repower");

    // R10 detection armed only in sleep, needs a fresh edge
    go_norm();
    wake_n = 1'b0; cyc(WF + 2);
    chk(P_NRM, "R10 wake pin ignored in normal");
    wake_n = 1'b1;
    go_pre();
    wake_n = 1'b0; cyc(WF + 1);
    chk(P_PRE, "R10 wake pin ignored in pre-normal");
    wake_n = 1'b1;
    go_norm();
    bus_rx = 1'b0; cyc(1);
    en_in = 1'b0; cyc(SL);
    chk(P_SLP, "R10 sleep entered with bus dominant");
    cyc(BF + 2);
    chk(P_SLP, "R10 no wake without new edge");
    bus_rx = 1'b1; cyc(1);
    bus_rx = 1'b0; cyc(BF);
    chk(P_REM, "R10 wake after fresh edge");
    bus_rx = 1'b1;

    // R11 simultaneous completion
    go_sleep();
    wake_n = 1'b0; cyc(WF - BF);
    bus_rx = 1'b0; cyc(BF - 1);
    chk(P_SLP, "R11 neither filter done");
    cyc(1);
    chk(P_LOC, "R11 local wins tie");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule